// File: doc/BRIEF.md
# Auxiliary Pulse Clock Divider

This block derives a slow, always-running auxiliary clock from the master clock. It gives control logic a timing reference that keeps ticking while the main data-path clocks are gated off between bursts. The block has no enable input, so nothing but reset can stop it.

A 4-bit rate value N sets the pulse period to N+1 master clock cycles. In each period the output is high for exactly two cycles and low for the remaining N-1. A rate of 0 or 1 parks the output high, which stops the divider toggling and saves power. A new rate is adopted only when the current period ends, so a rate change never makes a shortened pulse. The output comes straight from a flip-flop, so it carries no decode glitches.

Top module: `aux_pulse_divider`

## Requirements
- R1: In the first cycle after the synchronous reset is released, the output is high, and a full two-cycle high phase starts there. While reset is asserted the output reads high.
- R2: With a rate N from 2 to 15 held on `rate_i`, the output repeats with a period of exactly N+1 master clock cycles. This includes the limits N=2 and N=15.
- R3: Within each period, the output is high for 2 consecutive master clock cycles and then low for N-1 consecutive cycles.
- R4: A rate of 0 or 1 holds the output high in every cycle, with no toggling.
- R5: A rate change presented in the middle of a period does not affect that period. The current period finishes with the old rate. The new rate is sampled at the clock edge that ends the period and governs the next period.
- R6: While the output is parked by rate 0 or 1, the rate input is sampled at every edge. When a rate of 2 or more is sampled, the output stays high for 2 more cycles and then follows R2 and R3 with the new rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous reset, active high |
| rate_i | input | 4 | Rate value N; 0 and 1 park the output high |
| aux_clk_o | output | 1 | Registered auxiliary pulse clock |

## Verification
Each output value follows from the state settled at one clock edge. The rate input is sampled at the edge that ends a period, and its effect appears in the cycle just after that edge. A reset edge shows its high output one cycle later. The bench drives inputs on the falling edge and queues the value due just after the next rising edge. It compares that value 1 ns after the rising edge, so every expectation lines up with the single register on the output path. Rate changes are placed both at period boundaries and in the middle of a period, to show that only the boundary sample counts.

// File: rtl/apd_pkg.sv
package apd_pkg;
    // Default width of the rate field.
    parameter int unsigned RATE_W_DEF = 4;
    // Cycles the output stays high in each period; rates below this park it.
    parameter int unsigned PULSE_HIGH = 2;
endpackage

// File: rtl/apd_rate_hold.sv
module apd_rate_hold #(
    parameter int unsigned RATE_W = apd_pkg::RATE_W_DEF
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              wrap_i,
    output logic [RATE_W-1:0] rate_o,
    output logic              off_o,
    output logic              off_next_o
);
    localparam logic [RATE_W-1:0] OFF_LIMIT = RATE_W'(apd_pkg::PULSE_HIGH);

    typedef struct packed {
        logic [RATE_W-1:0] rate;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Adopt a new rate only on reset or when a period closes.
        if (rst_i || wrap_i) begin
            st_d.rate = rate_i;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign rate_o     = st_q.rate;
    assign off_o      = (st_q.rate < OFF_LIMIT);
    assign off_next_o = (st_d.rate < OFF_LIMIT);

    // R5: the active rate stays fixed until a period boundary
    rate_midperiod_stable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !wrap_i |=> (st_q.rate == $past(st_q.rate)));
endmodule

// File: rtl/apd_phase_cnt.sv
module apd_phase_cnt #(
    parameter int unsigned RATE_W = apd_pkg::RATE_W_DEF
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [RATE_W-1:0] limit_i,
    input  logic              off_i,
    output logic [RATE_W-1:0] cnt_next_o,
    output logic              wrap_o
);
    typedef struct packed {
        logic [RATE_W-1:0] cnt;
    } phase_t;

    phase_t st_d, st_q;
    logic   wrap;

    // A period ends on its last count, or on every cycle while parked.
    assign wrap = off_i || (st_q.cnt == limit_i);

    always_comb begin
        st_d = st_q;
        if (rst_i || wrap) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign cnt_next_o = st_d.cnt;
    assign wrap_o     = wrap;

    // R2: the phase never runs past the last count of the active period
    cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !off_i |-> (st_q.cnt <= limit_i));
endmodule

// File: rtl/apd_pulse_shape.sv
module apd_pulse_shape #(
    parameter int unsigned RATE_W = apd_pkg::RATE_W_DEF
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              off_next_i,
    input  logic [RATE_W-1:0] cnt_next_i,
    output logic              aux_o
);
    localparam logic [RATE_W-1:0] HIGH_LIMIT = RATE_W'(apd_pkg::PULSE_HIGH);

    typedef struct packed {
        logic aux;
    } shape_t;

    shape_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst_i) begin
            st_d.aux = 1'b1;
        end else begin
            st_d.aux = off_next_i || (cnt_next_i < HIGH_LIMIT);
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign aux_o = st_q.aux;

    // R3: once the output rises it holds high for a second cycle
    high_two_cycles_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(st_q.aux) |=> st_q.aux);
endmodule

// File: rtl/aux_pulse_divider.sv
module aux_pulse_divider #(
    parameter int unsigned RATE_W = apd_pkg::RATE_W_DEF
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              aux_clk_o
);
    logic [RATE_W-1:0] rate_act;
    logic [RATE_W-1:0] cnt_next;
    logic              off_now;
    logic              off_next;
    logic              wrap;

    apd_rate_hold #(.RATE_W(RATE_W)) u_hold (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .rate_i     (rate_i),
        .wrap_i     (wrap),
        .rate_o     (rate_act),
        .off_o      (off_now),
        .off_next_o (off_next)
    );

    apd_phase_cnt #(.RATE_W(RATE_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .limit_i    (rate_act),
        .off_i      (off_now),
        .cnt_next_o (cnt_next),
        .wrap_o     (wrap)
    );

    apd_pulse_shape #(.RATE_W(RATE_W)) u_shape (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .off_next_i (off_next),
        .cnt_next_i (cnt_next),
        .aux_o      (aux_clk_o)
    );

    // R4: a parked divider keeps its output high
    parked_high_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        off_now |-> aux_clk_o);
endmodule

// File: tb/aux_pulse_divider_bench.sv
`timescale 1ns/1ps
module aux_pulse_divider_bench;
    localparam int RATE_W = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic [RATE_W-1:0] rate;
    logic              aux;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    item_t q[$];

    // Reference state, built from the requirements.
    int m_rate = 0;
    int m_cnt  = 0;

    always #2.5 clk = ~clk;

    aux_pulse_divider #(.RATE_W(RATE_W)) u_aux_pulse_divider (
        .clk_i     (clk),
        .rst_i     (rst),
        .rate_i    (rate),
        .aux_clk_o (aux)
    );

    // Drive one cycle at the falling edge and queue the value due after the next rising edge.
    task automatic drive(input logic r, input int n, input string tag);
        item_t it;
        @(negedge clk);
        rst  = r;
        rate = RATE_W'(n);
        if (r) begin
            m_cnt  = 0;
            m_rate = n;
        end else if (m_rate < 2 || m_cnt == m_rate) begin
            m_cnt  = 0;
            m_rate = n;
        end else begin
            m_cnt  = m_cnt + 1;
        end
        it.exp = r || (m_rate < 2) || (m_cnt < 2);
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic run(input int n, input int cycles, input string tag);
        for (int i = 0; i < cycles; i++) drive(1'b0, n, tag);
    endtask

    // Monitor: compare 1 ns after each rising edge.
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                it = q.pop_front();
                checks++;
                if (aux !== it.exp) begin
                    errors++;
                    $display("FAIL %s: aux_clk_o=%b expected %b at %0t", it.tag, aux, it.exp, $time);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst  = 1'b1;
        rate = '0;
        // R1: reset state and immediate first pulse
        for (int i = 0; i < 3; i++) drive(1'b1, 3, "R1");
        run(3, 20, "R1/R2/R3 N=3");
        // R2 R3: smallest and largest active rates
        run(2, 15, "R2/R3 N=2");
        run(15, 40, "R2/R3 N=15");
        // R4: parked rates
        run(0, 12, "R4 N=0");
        run(1, 10, "R4 N=1");
        // R6: leaving the parked state
        run(7, 30, "R6 N=7");
        // R5: change in the middle of a period
        run(9, 4, "R5 N=9 partial");
        run(4, 30, "R5 N=4 after mid change");
        run(5, 2, "R5 N=5 brief");
        run(12, 30, "R5 N=12");
        // R1: reset during a running period
        drive(1'b1, 6, "R1 mid reset");
        drive(1'b1, 6, "R1 mid reset");
        run(6, 25, "R1/R2 N=6");
        run(1, 6, "R4 N=1 again");
        run(2, 9, "R6 N=2");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule